// File: doc/BRIEF.md
# Dual-Lane Multiply-Accumulate Datapath

This block is the arithmetic core of a signal-processing engine. Two multiply-accumulate lanes work in the same clock cycle. Each lane has its own 16-bit data operand, and both lanes share one 16-bit coefficient, so a single coefficient stream can drive two filter taps or two channels at once. Each operand is widened to 17 bits by sign or zero extension. The two 17-bit values are multiplied, and the product is added to or subtracted from one of four 40-bit accumulators.

The block has two stages. Stage 1 forms the products and registers them. Stage 2 reads the chosen accumulator, adds or subtracts the product, applies the chosen saturation, and writes the accumulator back at the end of that cycle. Saturation can be turned off, which lets the result wrap modulo 2^40. When it is on, it clamps either at the signed 32-bit limits or at the signed 40-bit limits. Each accumulator has a sticky overflow flag. If both lanes target the same accumulator in one cycle, lane 0 wins and a conflict pulse is raised. All four accumulators are visible at the outputs.

Top module: `dual_mac`

## Requirements
- R1: While rst_ni is low, all accumulators read zero, all overflow flags read zero and conflict_o reads zero.
- R2: Each operand is widened to 17 bits. A data operand is treated as signed (bit 15 replicated) when its dat_sgn_i bit is 1 and is zero-extended when that bit is 0. The coefficient follows coef_sgn_i in the same way.
- R3: An operation presented at a rising edge with its lane_en_i bit set shows its result on acc_o after the next rising edge. acc_o holds accumulator k in bits [40k+39:40k].
- R4: When sub_i[l] is 0, lane l adds its product to the accumulator. When sub_i[l] is 1, lane l subtracts it.
- R5: Both lanes multiply the same coef_i by their own data operands. In one cycle they can update two different accumulators, which are selected by dst_i[2l+1:2l].
- R6: With sat_en_i=1 and sat40_i=0, a result above 2^31-1 becomes 0x007FFFFFFF and a result below -2^31 becomes 0xFF80000000. Either case sets ovf_o[k] of the target accumulator.
- R7: With sat_en_i=1 and sat40_i=1, a result outside the signed 40-bit range clamps to 0x7FFFFFFFFF or 0x8000000000 and sets ovf_o[k].
- R8: With sat_en_i=0, the result wraps modulo 2^40. ovf_o[k] is set only when the exact result leaves the signed 40-bit range. A result beyond 32 bits is kept unclamped.
- R9: Overflow flags are sticky. Only reset clears them.
- R10: If both lanes are enabled and target the same accumulator, only lane 0's result is written. conflict_o is high for exactly the cycle in which that write becomes visible.
- R11: Operations on the same accumulator in consecutive cycles all accumulate, with no bubble and no lost update.
- R12: A lane whose lane_en_i bit is 0 changes no accumulator and no flag, whatever its other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_en_i | input | 2 | Per-lane operation valid |
| data_i | input | 32 | Lane data operands, lane l in [16l+15:16l] |
| dat_sgn_i | input | 2 | Per-lane data signedness |
| coef_i | input | 16 | Shared coefficient |
| coef_sgn_i | input | 1 | Coefficient signedness |
| sub_i | input | 2 | Per-lane subtract select |
| dst_i | input | 4 | Per-lane accumulator index |
| sat_en_i | input | 1 | Saturation enable |
| sat40_i | input | 1 | Saturation limit: 1 = 40-bit, 0 = 32-bit |
| acc_o | output | 160 | Accumulator file contents |
| ovf_o | output | 4 | Sticky overflow flag per accumulator |
| conflict_o | output | 1 | Destination conflict pulse |

## Verification
The properties assume that rst_ni is held low for at least two rising edges, because the conflict and saturation checks look two cycles back. They also assume that the control inputs are known whenever a lane is enabled. The stimulus changes inputs only on falling edges and holds reset for several cycles. The window checks tie each result to the lane 0 destination, which always wins arbitration. The stimulus therefore includes both conflicting and non-conflicting pairs while saturation is on.

// File: rtl/dual_mac_pkg.sv
package dual_mac_pkg;

  typedef enum logic [1:0] {
    SAT_OFF    = 2'd0,
    SAT_NARROW = 2'd1,
    SAT_WIDE   = 2'd2
  } sat_mode_e;

  function automatic sat_mode_e pick_mode(logic en, logic wide);
    if (!en) return SAT_OFF;
    return wide ? SAT_WIDE : SAT_NARROW;
  endfunction

endpackage

// File: rtl/dual_mac_mul.sv
module dual_mac_mul #(
  parameter int DATA_W = 16,
  localparam int EXT_W = DATA_W + 1,
  localparam int PROD_W = 2 * EXT_W
) (
  input  logic [DATA_W-1:0]        a_i,
  input  logic                     a_sgn_i,
  input  logic [DATA_W-1:0]        b_i,
  input  logic                     b_sgn_i,
  output logic signed [PROD_W-1:0] prod_o
);

  logic signed [EXT_W-1:0] a_x, b_x;

  always_comb begin
    a_x    = {a_sgn_i & a_i[DATA_W-1], a_i};
    b_x    = {b_sgn_i & b_i[DATA_W-1], b_i};
    prod_o = a_x * b_x;
  end

endmodule

// File: rtl/dual_mac_addsat.sv
module dual_mac_addsat
  import dual_mac_pkg::*;
#(
  parameter int ACC_W    = 40,
  parameter int PROD_W   = 34,
  parameter int NARROW_W = 32
) (
  input  logic [ACC_W-1:0]         acc_i,
  input  logic signed [PROD_W-1:0] prod_i,
  input  logic                     sub_i,
  input  sat_mode_e                mode_i,
  output logic [ACC_W-1:0]         res_o,
  output logic                     ovf_o
);

  localparam int SUM_W = ACC_W + 1;
  localparam logic signed [SUM_W-1:0] WIDE_MAX   = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] WIDE_MIN   = {2'b11, {(ACC_W-1){1'b0}}};
  localparam logic signed [SUM_W-1:0] NARROW_MAX = {{(SUM_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] NARROW_MIN = {{(SUM_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

  logic signed [SUM_W-1:0] acc_x, prod_x, sum;

  always_comb begin
    acc_x  = {acc_i[ACC_W-1], acc_i};
    prod_x = SUM_W'(prod_i);
    sum    = sub_i ? (acc_x - prod_x) : (acc_x + prod_x);
    res_o  = sum[ACC_W-1:0];
    ovf_o  = 1'b0;
    unique case (mode_i)
      SAT_WIDE: begin
        if (sum > WIDE_MAX) begin
          res_o = WIDE_MAX[ACC_W-1:0];
          ovf_o = 1'b1;
        end else if (sum < WIDE_MIN) begin
          res_o = WIDE_MIN[ACC_W-1:0];
          ovf_o = 1'b1;
        end
      end
      SAT_NARROW: begin
        if (sum > NARROW_MAX) begin
          res_o = NARROW_MAX[ACC_W-1:0];
          ovf_o = 1'b1;
        end else if (sum < NARROW_MIN) begin
          res_o = NARROW_MIN[ACC_W-1:0];
          ovf_o = 1'b1;
        end
      end
      default: ovf_o = sum[SUM_W-1] ^ sum[SUM_W-2];
    endcase
  end

endmodule

// File: rtl/dual_mac_accfile.sv
module dual_mac_accfile #(
  parameter int ACC_W  = 40,
  parameter int N_ACC  = 4,
  parameter int N_LANE = 2,
  localparam int IDX_W = $clog2(N_ACC)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [N_LANE-1:0]                  wr_en_i,
  input  logic [N_LANE-1:0][IDX_W-1:0]       wr_idx_i,
  input  logic [N_LANE-1:0][ACC_W-1:0]       wr_data_i,
  input  logic [N_LANE-1:0]                  wr_ovf_i,
  output logic [N_ACC-1:0][ACC_W-1:0]        acc_q_o,
  output logic [N_ACC-1:0]                   ovf_q_o,
  output logic                               conflict_q_o
);

  logic [N_ACC-1:0][ACC_W-1:0] acc_q, acc_d;
  logic [N_ACC-1:0]            ovf_q, ovf_d;
  logic                        conf_q, conf_d;
  logic [N_LANE-1:0]           win;

  // lower lane index has priority on a shared destination
  always_comb begin
    conf_d = 1'b0;
    for (int l = 0; l < N_LANE; l++) begin
      win[l] = wr_en_i[l];
      for (int m = 0; m < N_LANE; m++) begin
        if (m < l && wr_en_i[m] && wr_en_i[l] && wr_idx_i[m] == wr_idx_i[l]) begin
          win[l] = 1'b0;
          conf_d = 1'b1;
        end
      end
    end
  end

  always_comb begin
    acc_d = acc_q;
    ovf_d = ovf_q;
    for (int l = 0; l < N_LANE; l++) begin
      if (win[l]) begin
        acc_d[wr_idx_i[l]] = wr_data_i[l];
        if (wr_ovf_i[l]) ovf_d[wr_idx_i[l]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      ovf_q  <= '0;
      conf_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      ovf_q  <= ovf_d;
      conf_q <= conf_d;
    end
  end

  assign acc_q_o      = acc_q;
  assign ovf_q_o      = ovf_q;
  assign conflict_q_o = conf_q;

endmodule

// File: rtl/dual_mac.sv
module dual_mac
  import dual_mac_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ACC_W    = 40,
  parameter int N_ACC    = 4,
  parameter int N_LANE   = 2,
  parameter int NARROW_W = 32,
  localparam int IDX_W   = $clog2(N_ACC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_LANE-1:0]         lane_en_i,
  input  logic [N_LANE*DATA_W-1:0]  data_i,
  input  logic [N_LANE-1:0]         dat_sgn_i,
  input  logic [DATA_W-1:0]         coef_i,
  input  logic                      coef_sgn_i,
  input  logic [N_LANE-1:0]         sub_i,
  input  logic [N_LANE*IDX_W-1:0]   dst_i,
  input  logic                      sat_en_i,
  input  logic                      sat40_i,
  output logic [N_ACC*ACC_W-1:0]    acc_o,
  output logic [N_ACC-1:0]          ovf_o,
  output logic                      conflict_o
);

  localparam int EXT_W  = DATA_W + 1;
  localparam int PROD_W = 2 * EXT_W;

  logic signed [PROD_W-1:0]          prod_d [N_LANE];
  logic signed [PROD_W-1:0]          s1_prod [N_LANE];
  logic [N_LANE-1:0]                 s1_vld, s1_sub;
  logic [N_LANE-1:0][IDX_W-1:0]      s1_dst;
  sat_mode_e                         s1_mode;

  logic [N_ACC-1:0][ACC_W-1:0]       acc_q;
  logic [N_LANE-1:0][ACC_W-1:0]      wr_data;
  logic [N_LANE-1:0]                 wr_ovf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_mode <= SAT_OFF;
    else if (|lane_en_i) s1_mode <= pick_mode(sat_en_i, sat40_i);
  end

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    dual_mac_mul #(.DATA_W(DATA_W)) u_mul (
      .a_i     (data_i[l*DATA_W +: DATA_W]),
      .a_sgn_i (dat_sgn_i[l]),
      .b_i     (coef_i),
      .b_sgn_i (coef_sgn_i),
      .prod_o  (prod_d[l])
    );

    // stage 1: registered product, payload held while idle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_vld[l]  <= 1'b0;
        s1_sub[l]  <= 1'b0;
        s1_dst[l]  <= '0;
        s1_prod[l] <= '0;
      end else begin
        s1_vld[l] <= lane_en_i[l];
        if (lane_en_i[l]) begin
          s1_sub[l]  <= sub_i[l];
          s1_dst[l]  <= dst_i[l*IDX_W +: IDX_W];
          s1_prod[l] <= prod_d[l];
        end
      end
    end

    // stage 2: read live file, result lands in the same edge
    dual_mac_addsat #(
      .ACC_W    (ACC_W),
      .PROD_W   (PROD_W),
      .NARROW_W (NARROW_W)
    ) u_addsat (
      .acc_i  (acc_q[s1_dst[l]]),
      .prod_i (s1_prod[l]),
      .sub_i  (s1_sub[l]),
      .mode_i (s1_mode),
      .res_o  (wr_data[l]),
      .ovf_o  (wr_ovf[l])
    );
  end

  dual_mac_accfile #(
    .ACC_W  (ACC_W),
    .N_ACC  (N_ACC),
    .N_LANE (N_LANE)
  ) u_file (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (s1_vld),
    .wr_idx_i     (s1_dst),
    .wr_data_i    (wr_data),
    .wr_ovf_i     (wr_ovf),
    .acc_q_o      (acc_q),
    .ovf_q_o      (ovf_o),
    .conflict_q_o (conflict_o)
  );

  assign acc_o = acc_q;

endmodule

// File: rtl/dual_mac_chk.sv
module dual_mac_chk #(
  parameter int ACC_W    = 40,
  parameter int N_ACC    = 4,
  parameter int N_LANE   = 2,
  parameter int NARROW_W = 32,
  localparam int IDX_W   = $clog2(N_ACC)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [N_LANE-1:0]        lane_en_i,
  input logic [N_LANE*IDX_W-1:0]  dst_i,
  input logic                     sat_en_i,
  input logic                     sat40_i,
  input logic [N_ACC*ACC_W-1:0]   acc_o,
  input logic [N_ACC-1:0]         ovf_o,
  input logic                     conflict_o
);

  localparam logic signed [ACC_W-1:0] N_MAX = {{(ACC_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] N_MIN = {{(ACC_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

  logic [IDX_W-1:0] dst0_d1, dst0_d2;
  logic signed [ACC_W-1:0] acc_sel;
  logic same_dst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst0_d1 <= '0;
      dst0_d2 <= '0;
    end else begin
      dst0_d1 <= dst_i[IDX_W-1:0];
      dst0_d2 <= dst0_d1;
    end
  end

  assign acc_sel  = acc_o[dst0_d2*ACC_W +: ACC_W];
  assign same_dst = lane_en_i[0] && lane_en_i[1] && dst_i[0 +: IDX_W] == dst_i[IDX_W +: IDX_W];

  assert_sat32_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_en_i[0] && sat_en_i && !sat40_i |=> ##1 (acc_sel <= N_MAX && acc_sel >= N_MIN));

  assert_conflict_raise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    same_dst |=> ##1 conflict_o);

  assert_conflict_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> $past(same_dst, 2));

  assert_sticky_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o & $past(ovf_o)) == $past(ovf_o));

  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_en_i == '0 |=> ##1 ($stable(acc_o) && $stable(ovf_o)));

endmodule

bind dual_mac dual_mac_chk #(
  .ACC_W    (ACC_W),
  .N_ACC    (N_ACC),
  .N_LANE   (N_LANE),
  .NARROW_W (NARROW_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lane_en_i  (lane_en_i),
  .dst_i      (dst_i),
  .sat_en_i   (sat_en_i),
  .sat40_i    (sat40_i),
  .acc_o      (acc_o),
  .ovf_o      (ovf_o),
  .conflict_o (conflict_o)
);

// File: tb/dual_mac_bench.sv
module dual_mac_bench;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   lane_en_i = '0;
  logic [31:0]  data_i = '0;
  logic [1:0]   dat_sgn_i = '0;
  logic [15:0]  coef_i = '0;
  logic         coef_sgn_i = 1'b0;
  logic [1:0]   sub_i = '0;
  logic [3:0]   dst_i = '0;
  logic         sat_en_i = 1'b0;
  logic         sat40_i = 1'b0;
  logic [159:0] acc_o;
  logic [3:0]   ovf_o;
  logic         conflict_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  dual_mac u_dual_mac (
    .clk_i, .rst_ni, .lane_en_i, .data_i, .dat_sgn_i, .coef_i, .coef_sgn_i,
    .sub_i, .dst_i, .sat_en_i, .sat40_i, .acc_o, .ovf_o, .conflict_o
  );

  // ---------------- behavioural reference ----------------
  longint m_acc [4];
  bit     m_ovf [4];
  bit     m_conf;
  bit     p_vld [2];
  bit     p_sub [2];
  int     p_dst [2];
  longint p_prod [2];
  int     p_mode;

  function automatic longint widen(logic [15:0] v, bit sgn);
    return sgn ? longint'($signed(v)) : longint'(v);
  endfunction

  function automatic longint step(longint a, longint p, bit s, int mode, output bit ov);
    longint full, lo, hi, w;
    full = s ? a - p : a + p;
    ov = 1'b0;
    if (mode == 0) begin
      w = full & ((longint'(1) << 40) - 1);
      if (w >= (longint'(1) << 39)) w = w - (longint'(1) << 40);
      ov = (w != full);
      return w;
    end
    hi = (mode == 2) ? (longint'(1) << 39) - 1 : (longint'(1) << 31) - 1;
    lo = -hi - 1;
    if (full > hi) begin ov = 1'b1; return hi; end
    if (full < lo) begin ov = 1'b1; return lo; end
    return full;
  endfunction

  initial for (int k = 0; k < 4; k++) begin m_acc[k] = 0; m_ovf[k] = 0; end

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 4; k++) begin m_acc[k] = 0; m_ovf[k] = 0; end
      m_conf = 0;
      for (int l = 0; l < 2; l++) p_vld[l] = 0;
    end else begin
      longint old [4];
      bit ov;
      for (int k = 0; k < 4; k++) old[k] = m_acc[k];
      m_conf = p_vld[0] && p_vld[1] && p_dst[0] == p_dst[1];
      for (int l = 1; l >= 0; l--) begin
        if (p_vld[l] && !(l == 1 && m_conf)) begin
          m_acc[p_dst[l]] = step(old[p_dst[l]], p_prod[l], p_sub[l], p_mode, ov);
          if (ov) m_ovf[p_dst[l]] = 1;
        end
      end
      if (lane_en_i != 0) p_mode = !sat_en_i ? 0 : (sat40_i ? 2 : 1);
      for (int l = 0; l < 2; l++) begin
        p_vld[l] = lane_en_i[l];
        p_sub[l] = sub_i[l];
        p_dst[l] = int'(dst_i[2*l +: 2]);
        p_prod[l] = widen(data_i[16*l +: 16], dat_sgn_i[l]) * widen(coef_i, coef_sgn_i);
      end
    end
  end

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [39:0] acc(int k);
    return acc_o[40*k +: 40];
  endfunction

  // every-cycle comparison: latency and back-to-back accumulate (R3, R11)
  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int k = 0; k < 4; k++) begin
        chk($sformatf("R3 model acc%0d", k), 64'(acc(k)), 64'(m_acc[k][39:0]));
        chk($sformatf("R9 model ovf%0d", k), 64'(ovf_o[k]), 64'(m_ovf[k]));
      end
      chk("R10 model conflict", 64'(conflict_o), 64'(m_conf));
    end
  end

  // ---------------- stimulus ----------------
  task automatic put(logic [1:0] en, logic [15:0] d0, logic [15:0] d1, logic [1:0] ds,
                     logic [15:0] c, logic cs, logic [1:0] sb, logic [1:0] t0, logic [1:0] t1,
                     logic se, logic s40);
    lane_en_i = en; data_i = {d1, d0}; dat_sgn_i = ds; coef_i = c; coef_sgn_i = cs;
    sub_i = sb; dst_i = {t1, t0}; sat_en_i = se; sat40_i = s40;
    @(negedge clk_i);
    lane_en_i = '0;
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    for (int k = 0; k < 4; k++) chk("R1 reset acc", 64'(acc(k)), 64'h0);
    chk("R1 reset ovf", 64'(ovf_o), 64'h0);
    chk("R1 reset conflict", 64'(conflict_o), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R5: shared signed coef 3; lane0 signed -1, lane1 unsigned 65535
    put(2'b11, 16'hFFFF, 16'hFFFF, 2'b01, 16'd3, 1'b1, 2'b00, 2'd0, 2'd1, 1'b0, 1'b0);
    chk("R3 not yet written", 64'(acc(0)), 64'h0);
    @(negedge clk_i);
    chk("R2 R5 signed lane0", 64'(acc(0)), 64'hFF_FFFF_FFFD);
    chk("R2 R5 unsigned lane1", 64'(acc(1)), 64'h00_0002_FFFD);

    // R2 R4: unsigned coef 0x8000 times signed 2, subtracted
    put(2'b01, 16'd2, 16'd0, 2'b01, 16'h8000, 1'b0, 2'b01, 2'd2, 2'd0, 1'b0, 1'b0);
    @(negedge clk_i);
    chk("R4 subtract", 64'(acc(2)), 64'hFF_FFFF_0000);

    // R11: three consecutive adds of 4096 to acc3
    for (int i = 0; i < 3; i++) begin
      lane_en_i = 2'b01; data_i = 32'h0000_0010; dat_sgn_i = 2'b01; coef_i = 16'h0100;
      coef_sgn_i = 1'b1; sub_i = 2'b00; dst_i = 4'b0011; sat_en_i = 1'b0;
      @(negedge clk_i);
    end
    lane_en_i = '0;
    @(negedge clk_i);
    chk("R11 back-to-back", 64'(acc(3)), 64'h00_0000_3000);

    // R6: narrow saturation both directions
    put(2'b11, 16'hFFFF, 16'hFFFF, 2'b00, 16'hFFFF, 1'b0, 2'b01, 2'd0, 2'd1, 1'b1, 1'b0);
    @(negedge clk_i);
    chk("R6 clamp low", 64'(acc(0)), 64'hFF_8000_0000);
    chk("R6 clamp high", 64'(acc(1)), 64'h00_7FFF_FFFF);
    chk("R6 flags", 64'(ovf_o), 64'h3);

    // R8: no saturation, result beyond 32 bits is kept
    put(2'b10, 16'h0, 16'hFFFF, 2'b00, 16'hFFFF, 1'b0, 2'b00, 2'd0, 2'd1, 1'b0, 1'b0);
    @(negedge clk_i);
    chk("R8 no clamp", 64'(acc(1)), 64'h01_7FFE_0000);
    chk("R8 flags unchanged", 64'(ovf_o), 64'h3);

    // R7: wide saturation on acc2 after 200 large adds
    for (int i = 0; i < 200; i++) begin
      lane_en_i = 2'b01; data_i = 32'h0000_FFFF; dat_sgn_i = 2'b00; coef_i = 16'hFFFF;
      coef_sgn_i = 1'b0; sub_i = 2'b00; dst_i = 4'b0010; sat_en_i = 1'b1; sat40_i = 1'b1;
      @(negedge clk_i);
    end
    lane_en_i = '0;
    @(negedge clk_i);
    chk("R7 clamp wide", 64'(acc(2)), 64'h7F_FFFF_FFFF);
    chk("R7 flag", 64'(ovf_o), 64'h7);

    // R8: same run without saturation wraps acc3
    for (int i = 0; i < 200; i++) begin
      lane_en_i = 2'b01; data_i = 32'h0000_FFFF; dat_sgn_i = 2'b00; coef_i = 16'hFFFF;
      coef_sgn_i = 1'b0; sub_i = 2'b00; dst_i = 4'b0011; sat_en_i = 1'b0; sat40_i = 1'b0;
      @(negedge clk_i);
    end
    lane_en_i = '0;
    @(negedge clk_i);
    chk("R8 wrap", 64'(acc(3)), 64'hC7_FE70_30C8);
    chk("R8 wrap flag", 64'(ovf_o), 64'hF);

    // R10: both lanes to acc0, lane0 wins
    put(2'b11, 16'd1, 16'd5, 2'b11, 16'd1, 1'b1, 2'b00, 2'd0, 2'd0, 1'b0, 1'b0);
    chk("R10 no early pulse", 64'(conflict_o), 64'h0);
    @(negedge clk_i);
    chk("R10 lane0 wins", 64'(acc(0)), 64'hFF_8000_0001);
    chk("R10 pulse", 64'(conflict_o), 64'h1);
    @(negedge clk_i);
    chk("R10 pulse ends", 64'(conflict_o), 64'h0);

    // R12: lane0 disabled with live operands aimed at acc2
    put(2'b10, 16'h7FFF, 16'd1, 2'b11, 16'd1, 1'b1, 2'b01, 2'd2, 2'd1, 1'b0, 1'b0);
    @(negedge clk_i);
    chk("R12 disabled lane", 64'(acc(2)), 64'h7F_FFFF_FFFF);
    chk("R12 enabled lane", 64'(acc(1)), 64'h01_7FFE_0001);

    // R9: flags survive quiet ops, cleared only by reset
    put(2'b01, 16'd1, 16'd0, 2'b01, 16'd1, 1'b1, 2'b00, 2'd3, 2'd0, 1'b0, 1'b0);
    @(negedge clk_i);
    chk("R9 sticky", 64'(ovf_o), 64'hF);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R9 reset clears", 64'(ovf_o), 64'h0);
    chk("R1 reset acc0", 64'(acc(0)), 64'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule